// File: doc/BRIEF.md
# Clock Gate Group with Stop Status

This block switches a group of up to 32 module clocks on and off from one control word. Each bit of the control register belongs to one gate. Writing a 1 stops that module clock and writing a 0 lets it run. Software changes one gate by reading the control word, editing the bit and writing the word back. A read-only status word reports which gates have actually stopped. Each status bit follows its control bit after a fixed number of clock cycles, so that after an enable software can poll until the bit reads 0.

The group may be sparsely populated. The parameter `IMPL_MASK` marks the gates that exist. Bits without a gate ignore writes and read back as 0. If the status word is left out (`HAS_STATUS = 0`), a read of the status address returns the control word. Each gate is a latch-based clock enable that is transparent only while the clock is low, so a gated clock never produces a shortened pulse. In this design every gate takes its parent clock from the register clock `clk`.

Top module: `clk_gate_group`

## Requirements
- R1: After reset, every implemented control bit reads 1 (stopped), every unimplemented bit reads 0, the status word equals the control word, and every gated clock stays low.
- R2: A write with `regWrEn` high at address 0 stores `regWrData` masked by `IMPL_MASK` into the control word. The new value can be read at address 0 from the next cycle. In the control word, 1 means stop and 0 means run.
- R3: Unimplemented bits (`IMPL_MASK[n]` = 0) read 0 at both addresses, are unchanged by writes, and their gated clock output stays 0.
- R4: With `HAS_STATUS` = 1, address 1 returns the status word, in which 1 means stopped. A control change written at clock edge k appears in the status word after edge k+`STAT_LAT` and not before, for enables and for disables alike. `STAT_LAT` is between 1 and a few cycles, far below a 1000-read polling budget.
- R5: The gated clock of implemented gate n equals `clk` while its status bit is 0 and is held low while the bit is 1. The enable changes only while `clk` is low: the first changed high phase follows edge k+`STAT_LAT`+1.
- R6: A write to address 1 changes neither the control word nor the status word.
- R7: With `HAS_STATUS` = 0, a read of address 1 returns the control word.
- R8: A write that changes only bit n leaves every other control bit, status bit and gated clock unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock; also the parent clock of every gate |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Write strobe for the register port |
| regAddr | input | 1 | Register select: 0 control, 1 status |
| regWrData | input | NUM_GATES | Write data; bit n belongs to gate n |
| regRdData | output | NUM_GATES | Combinational read data for `regAddr` |
| modClk | output | NUM_GATES | Gated module clocks |

## Verification
The bench sweeps every one of the 32 bit positions of a sparse mask. For each bit it enables the gate with a read-modify-write and then disables it again. On every cycle of the lag it samples the status word, and it samples the gated clocks in the high phases on both sides of the switch. A lag off by one cycle would show a status bit that flips one sample early or late. A gate whose latch passes its enable during the high phase would show the new clock level one phase too soon. A missing mask would let an unimplemented bit read back 1 or toggle its clock. A second instance without a status word, together with writes aimed at the status address, catches a design that decodes address 1 as writable or returns the pipeline for it.

// File: rtl/cgg_pkg.sv
`timescale 1ns/1ps
package cgg_pkg;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  typedef struct packed {
    logic wrCtrl;   // commit write data to control word
    logic selStat;  // read mux selects status side
  } cggStrobe_t;
endpackage

// File: rtl/cgg_ctrl.sv
`timescale 1ns/1ps
module cgg_ctrl
  import cgg_pkg::*;
(
  input  logic       regWrEn,
  input  logic       regAddr,
  output cggStrobe_t strobe
);
  always_comb begin
    strobe.wrCtrl  = regWrEn && (regAddr == ADDR_CTRL);
    strobe.selStat = (regAddr == ADDR_STAT);
  end
endmodule

// File: rtl/cgg_gate.sv
`timescale 1ns/1ps
module cgg_gate (
  input  logic clk,
  input  logic runEn,
  output logic gclk
);
  logic enLat;

  // transparent only in the low phase, so the enable is steady while clk is high
  always_latch begin
    if (!clk) enLat = runEn;
  end

  assign gclk = clk & enLat;
endmodule

// File: rtl/cgg_datapath.sv
`timescale 1ns/1ps
module cgg_datapath
  import cgg_pkg::*;
#(
  parameter int NUM_GATES = 32,
  parameter logic [NUM_GATES-1:0] IMPL_MASK = '1,
  parameter int STAT_LAT = 3,
  parameter bit HAS_STATUS = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cggStrobe_t           strobe,
  input  logic [NUM_GATES-1:0] wrData,
  output logic [NUM_GATES-1:0] rdData,
  output logic [NUM_GATES-1:0] modClk
);
  localparam int QW = $clog2(STAT_LAT + 1);
  localparam logic [QW-1:0] QUIET_FULL = QW'(STAT_LAT);

  logic [NUM_GATES-1:0] ctrlQ, ctrlNext;
  logic [NUM_GATES-1:0] pipeQ [STAT_LAT];
  logic [NUM_GATES-1:0] statQ;
  logic [QW-1:0]        quietQ;

  always_comb begin
    ctrlNext = ctrlQ;
    if (strobe.wrCtrl) ctrlNext = wrData & IMPL_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlQ <= IMPL_MASK;
    else       ctrlQ <= ctrlNext;
  end

  // handshake lag from control to the stop state the gates act on
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAT_LAT; s++) pipeQ[s] <= IMPL_MASK;
    end else begin
      pipeQ[0] <= ctrlQ;
      for (int s = 1; s < STAT_LAT; s++) pipeQ[s] <= pipeQ[s-1];
    end
  end

  assign statQ = pipeQ[STAT_LAT-1];

  generate
    if (HAS_STATUS) begin : gStat
      assign rdData = strobe.selStat ? statQ : ctrlQ;
    end else begin : gNoStat
      assign rdData = ctrlQ;
    end
  endgenerate

  for (genvar g = 0; g < NUM_GATES; g++) begin : gGate
    if (IMPL_MASK[g]) begin : gOn
      cgg_gate uGate (.clk(clk), .runEn(~statQ[g]), .gclk(modClk[g]));
    end else begin : gOff
      assign modClk[g] = 1'b0;
    end
  end

  // cycles since the control word last changed, saturating at the lag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       quietQ <= QUIET_FULL;
    else if (ctrlNext != ctrlQ)      quietQ <= '0;
    else if (quietQ != QUIET_FULL)   quietQ <= quietQ + 1'b1;
  end

  AST_RD_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & ~IMPL_MASK) == '0); // R3
  AST_STAT_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (statQ & ~IMPL_MASK) == '0); // R3
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrCtrl |=> ctrlQ == ($past(wrData) & IMPL_MASK)); // R2
  AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrCtrl |=> $stable(ctrlQ)); // R6
  AST_STAT_SETTLES: assert property (@(posedge clk) disable iff (!rstN)
    quietQ == QUIET_FULL |-> statQ == ctrlQ); // R4
endmodule

// File: rtl/clk_gate_group.sv
`timescale 1ns/1ps
module clk_gate_group
  import cgg_pkg::*;
#(
  parameter int NUM_GATES = 32,
  parameter logic [NUM_GATES-1:0] IMPL_MASK = 32'hB7E1_5A3C,
  parameter int STAT_LAT = 3,
  parameter bit HAS_STATUS = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic                 regAddr,
  input  logic [NUM_GATES-1:0] regWrData,
  output logic [NUM_GATES-1:0] regRdData,
  output logic [NUM_GATES-1:0] modClk
);
  cggStrobe_t strobe;

  cgg_ctrl uCtrl (
    .regWrEn(regWrEn),
    .regAddr(regAddr),
    .strobe (strobe)
  );

  cgg_datapath #(
    .NUM_GATES (NUM_GATES),
    .IMPL_MASK (IMPL_MASK),
    .STAT_LAT  (STAT_LAT),
    .HAS_STATUS(HAS_STATUS)
  ) uDp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrData(regWrData),
    .rdData(regRdData),
    .modClk(modClk)
  );
endmodule

// File: tb/clk_gate_group_test.sv
`timescale 1ns/1ps
module clk_gate_group_test;
  localparam logic [31:0] MASK = 32'hB7E1_5A3C;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic        wrEn = 1'b0, addr = 1'b0;
  logic [31:0] wrData = '0, rdData, gclk;
  logic        nsWrEn = 1'b0, nsAddr = 1'b0;
  logic [31:0] nsWrData = '0, nsRdData, nsGclk;

  int checks = 0, errors = 0;

  clk_gate_group #(.NUM_GATES(32), .IMPL_MASK(MASK), .STAT_LAT(LAT), .HAS_STATUS(1'b1)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(wrEn), .regAddr(addr),
    .regWrData(wrData), .regRdData(rdData), .modClk(gclk));

  clk_gate_group #(.NUM_GATES(32), .IMPL_MASK(MASK), .STAT_LAT(LAT), .HAS_STATUS(1'b0)) uutNs (
    .clk(clk), .rstN(rstN), .regWrEn(nsWrEn), .regAddr(nsAddr),
    .regWrData(nsWrData), .regRdData(nsRdData), .modClk(nsGclk));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // read is combinational; caller sits mid high phase
  task automatic peek(input logic a, output logic [31:0] v);
    addr = a;
    #0.2;
    v = rdData;
  endtask

  // ends 1 ns after the edge that captures the write
  task automatic writeReg(input logic a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk);
    #1;
    wrEn = 1'b0;
  endtask

  task automatic nsWrite(input logic a, input logic [31:0] d);
    @(negedge clk);
    nsWrEn = 1'b1; nsAddr = a; nsWrData = d;
    @(posedge clk);
    #1;
    nsWrEn = 1'b0;
  endtask

  // write ctrl and trace status lag and gate switch-over
  task automatic writeAndTrace(input logic [31:0] d, input string req);
    logic [31:0] oldCtrl, newCtrl, v;
    peek(1'b0, oldCtrl);
    newCtrl = d & MASK;
    writeReg(1'b0, d);
    peek(1'b0, v);  chk({req, " R2 ctrl readback"}, v, newCtrl);
    peek(1'b1, v);  chk({req, " R4 status before lag"}, v, oldCtrl);
    for (int i = 1; i <= LAT; i++) begin
      @(posedge clk); #1;
      peek(1'b1, v);
      chk({req, " R4 status lag step"}, v, (i == LAT) ? newCtrl : oldCtrl);
    end
    chk({req, " R5 gate still old in this high phase"}, gclk, ~oldCtrl & MASK);
    @(posedge clk); #1;
    chk({req, " R5 R3 gate switched"}, gclk, ~newCtrl & MASK);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    finishRun();
  end

  initial begin
    logic [31:0] v, ctrlNow, statNow;
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    peek(1'b0, v); chk("R1 reset ctrl", v, MASK);
    peek(1'b1, v); chk("R1 reset status", v, MASK);
    chk("R1 reset gates low", gclk, 32'h0);
    @(negedge clk); #0.5;
    chk("R1 gates low in low phase", gclk, 32'h0);
    @(posedge clk); #1;

    // R3: whole-word patterns; unimplemented bits must stay clear
    writeAndTrace(32'h0000_0000, "R3 all run");
    writeAndTrace(32'hFFFF_FFFF, "R3 all stop");
    writeAndTrace(32'h5555_AAAA, "R2 pattern A");
    writeAndTrace(32'hFFFF_FFFF, "R2 pattern B");

    // R8: per-bit read-modify-write sweep over all 32 positions
    for (int n = 0; n < 32; n++) begin
      peek(1'b0, ctrlNow);
      writeAndTrace(ctrlNow & ~(32'h1 << n), "R8 enable bit");
      peek(1'b0, v);
      chk("R8 other bits unchanged", v & ~(32'h1 << n), ctrlNow & ~(32'h1 << n));
      peek(1'b0, ctrlNow);
      writeAndTrace(ctrlNow | (32'h1 << n), "R8 disable bit");
    end

    // R6: writes at the status address are ignored
    writeAndTrace(32'h0F0F_0F0F, "R6 setup");
    peek(1'b0, ctrlNow);
    peek(1'b1, statNow);
    writeReg(1'b1, 32'hA5A5_5A5A);
    for (int i = 0; i <= LAT + 1; i++) begin
      @(posedge clk); #1;
      peek(1'b0, v); chk("R6 ctrl unchanged", v, ctrlNow);
      peek(1'b1, v); chk("R6 status unchanged", v, statNow);
      chk("R6 gates unchanged", gclk, ~ctrlNow & MASK);
    end

    // R7: instance without status returns control at address 1
    nsAddr = 1'b1; #0.2;
    chk("R7 reset status mirrors ctrl", nsRdData, MASK);
    nsWrite(1'b0, 32'h1234_5678);
    nsAddr = 1'b1; #0.2;
    chk("R7 status mirrors ctrl A", nsRdData, 32'h1234_5678 & MASK);
    nsWrite(1'b0, 32'h0);
    nsAddr = 1'b1; #0.2;
    chk("R7 status mirrors ctrl B", nsRdData, 32'h0);
    nsWrite(1'b1, 32'hFFFF_FFFF);
    nsAddr = 1'b1; #0.2;
    chk("R7 R6 status write ignored", nsRdData, 32'h0);
    repeat (LAT + 1) @(posedge clk);
    #1;
    chk("R7 R5 gates run", nsGclk, MASK);

    finishRun();
  end
endmodule